// File: doc/BRIEF.md
# Serial Port Data Register Path

This block sits between a processor register bus and the serial shift logic of a serial port. It keeps one byte-wide receive store and one byte-wide transmit store. With queueing disabled each store behaves as a single holding register. With queueing enabled each store becomes a 16-entry first-in first-out queue. The same bus address and the same two status flags (data ready, transmit request) serve both modes.

A divisor-access select redirects the low addresses to a pair of byte latches. Together they form a 16-bit baud divisor. A free-running counter uses this divisor to produce a tick at sixteen times the baud rate. Received characters are masked to the programmed word length and right-justified before they are stored. Shifting and framing, interrupts and modem lines belong to other blocks.

Top module: `uart_regpath`

## Requirements
- R1: After reset, data_ready is 0, tx_request is 1, tx_valid is 0, address 0 reads 0, and both divisor latches read 0.
- R2: With fifo_en 0, a character pushed on rx_char_valid is held and sets data_ready. A newer character replaces an unread one. A bus read of address 0 (divisor_access 0) returns the held character, and afterwards data_ready is 0 and address 0 reads 0.
- R3: Received characters are masked to the word length before storage. word_len code 0, 1, 2 and 3 keep the low 5, 6, 7 and 8 bits, and the upper bits read as 0.
- R4: With fifo_en 1, received characters are read back in arrival order. Up to 16 are kept, and a character that arrives while 16 are stored is dropped. data_ready stays 1 while at least one is stored.
- R5: A read of address 0 while no received character is stored returns 0 and leaves the queue unchanged, so the next pushed character is the next one read.
- R6: With fifo_en 0, a bus write to address 0 (divisor_access 0) loads the transmit holding register: tx_request drops to 0 and tx_valid rises, and a second write before the handoff replaces the byte. On a cycle with tx_valid and tx_ready both high, the byte leaves, tx_valid falls and tx_request returns to 1.
- R7: With fifo_en 1, bus writes to address 0 are appended to a 16-entry transmit queue, and a write while 16 are queued is dropped. The head byte is offered on tx_data and leaves on each tx_valid and tx_ready handshake, in write order. tx_request is 1 exactly while the queue is empty.
- R8: With divisor_access 0, address 0 is shared: a read selects the receive store and a write selects the transmit store, and neither access affects the other.
- R9: With divisor_access 1, addresses 0 and 1 read and write the low and high divisor bytes, and the receive and transmit stores are untouched.
- R10: baud_tick pulses once every D clock cycles, where D is the 16-bit divisor {high, low}. A divisor of 0 acts as 1, giving a tick on every cycle.
- R11: Bus data bits 31:8 always read as 0, and their written values are ignored.
- R12: Any change of fifo_en empties both stores: data_ready becomes 0 and tx_request becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe; a read of address 0 consumes a received character |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; only bits 7:0 are used |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| divisor_access | input | 1 | 1 maps addresses 0 and 1 to the divisor latches |
| fifo_en | input | 1 | 1 selects queue mode for both stores |
| word_len | input | 2 | Received character length code (0 to 3 means 5 to 8 bits) |
| rx_char_valid | input | 1 | Receive shift register delivers a character |
| rx_char | input | 8 | Received character |
| tx_ready | input | 1 | Transmit shift register is empty and accepts a byte |
| tx_valid | output | 1 | A byte is waiting for the transmit shift register |
| tx_data | output | 8 | Byte offered to the transmit shift register |
| data_ready | output | 1 | At least one received character is stored |
| tx_request | output | 1 | Transmit store is empty |
| baud_tick | output | 1 | Oversampling tick at 16 times the baud rate |

## Verification
The embedded properties watch, on every cycle, these behaviours: the queue occupancy bound, full-queue drops, the empty-read case leaving the read pointer alone, a single-register read clearing data ready, the transmit handoff raising the request flag, and the gap between divisor ticks. The directed scenarios must show what only a sequence reveals: the data order through each queue, masking for every word length, overwrite of an unread holding register, the tick period for several divisor values, the divisor latch mapping and the flush on a mode change.

// File: rtl/uart_regpath_pkg.sv
package uart_regpath_pkg;

   typedef enum logic [1:0] {
      WLEN_5 = 2'd0,
      WLEN_6 = 2'd1,
      WLEN_7 = 2'd2,
      WLEN_8 = 2'd3
   } wlen_e;

   localparam int unsigned CHAR_W     = 8;
   localparam int unsigned DATA_ADDR  = 0;

   // keep the low (5 + code) bits of a received character
   function automatic logic [CHAR_W-1:0] char_mask(input wlen_e len);
      logic [CHAR_W-1:0] m;
      m = {CHAR_W{1'b1}} >> (2'd3 - 2'(len));
      return m;
   endfunction

endpackage

// File: rtl/regpath_fifo.sv
module regpath_fifo #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             single_mode,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("regpath_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             do_pop, do_push;

   assign empty  = (cnt_q == '0);
   assign full   = single_mode ? !empty : (cnt_q == CNT_MAX);
   assign dout   = mem_q[rd_ptr_q];
   assign do_pop = pop && !empty;
   // single register mode always accepts (overwrite); queue mode drops on full
   assign do_push = push && (single_mode || !full || do_pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (flush) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (single_mode) begin
         if (do_push)     cnt_q <= CNT_W'(1);
         else if (do_pop) cnt_q <= '0;
      end else begin
         if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
         if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
         else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!flush && do_push) begin
         if (single_mode) mem_q[rd_ptr_q] <= din;
         else             mem_q[wr_ptr_q] <= din;
      end
   end

   // R4 R7: occupancy never exceeds the queue depth
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);

   // R4 R7: a push into a full queue without a pop is dropped
   assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!single_mode && full && push && !pop && !flush) |=> $stable(cnt_q));

   // R5: popping an empty queue moves no pointer
   assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> ($stable(rd_ptr_q) && cnt_q == '0));

endmodule

// File: rtl/regpath_baudgen.sv
module regpath_baudgen #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   generate
      if (DIV_W < 2) begin : g_bad_width
         $error("regpath_baudgen: DIV_W must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] eff_div;
   logic [DIV_W-1:0] last_cnt;

   // a zero divisor behaves as one
   assign eff_div  = (divisor == '0) ? DIV_W'(1) : divisor;
   assign last_cnt = eff_div - 1'b1;
   // >= so that shrinking the divisor mid-period wraps at once
   assign tick     = (cnt_q >= last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   // R10: with a divisor above one, ticks never come on adjacent cycles
   assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divisor > DIV_W'(1) && $stable(divisor)) |=> !tick);

endmodule

// File: rtl/uart_regpath.sv
module uart_regpath #(
   parameter int unsigned BUS_W      = 32,
   parameter int unsigned REG_ADDR_W = 3,
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned DIV_W      = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [BUS_W-1:0]      bus_wdata,
   output logic [BUS_W-1:0]      bus_rdata,
   input  logic                  divisor_access,
   input  logic                  fifo_en,
   input  logic [1:0]            word_len,
   input  logic                  rx_char_valid,
   input  logic [7:0]            rx_char,
   input  logic                  tx_ready,
   output logic                  tx_valid,
   output logic [7:0]            tx_data,
   output logic                  data_ready,
   output logic                  tx_request,
   output logic                  baud_tick
);
   import uart_regpath_pkg::*;

   localparam int unsigned DIV_BYTES = DIV_W / CHAR_W;
   localparam int unsigned PAD_W     = BUS_W - CHAR_W;

   generate
      if (BUS_W <= CHAR_W) begin : g_bad_bus
         $error("uart_regpath: BUS_W must exceed the character width");
      end
      if (DIV_W % CHAR_W != 0 || DIV_BYTES < 1) begin : g_bad_div
         $error("uart_regpath: DIV_W must be a whole number of bytes");
      end
      if (DIV_BYTES > (1 << REG_ADDR_W)) begin : g_bad_addr
         $error("uart_regpath: address space too small for divisor latches");
      end
   endgenerate

   // ---------------- access decode ----------------
   logic data_sel, rx_read, tx_write;
   assign data_sel = !divisor_access && (bus_addr == REG_ADDR_W'(DATA_ADDR));
   assign rx_read  = bus_rd && data_sel;
   assign tx_write = bus_wr && data_sel;

   // ---------------- mode change flush ----------------
   logic mode_q, flush;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= fifo_en;
   end
   assign flush = (mode_q != fifo_en);

   // ---------------- receive store ----------------
   logic [CHAR_W-1:0] rx_masked, rx_head;
   logic              rx_empty, rx_full;
   assign rx_masked = rx_char & char_mask(wlen_e'(word_len));

   regpath_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) i_rx_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .single_mode (!fifo_en),
      .push        (rx_char_valid),
      .pop         (rx_read),
      .din         (rx_masked),
      .dout        (rx_head),
      .empty       (rx_empty),
      .full        (rx_full)
   );
   assign data_ready = !rx_empty;

   // ---------------- transmit store ----------------
   logic tx_empty, tx_full;

   regpath_fifo #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) i_tx_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush       (flush),
      .single_mode (!fifo_en),
      .push        (tx_write),
      .pop         (tx_ready),
      .din         (bus_wdata[CHAR_W-1:0]),
      .dout        (tx_data),
      .empty       (tx_empty),
      .full        (tx_full)
   );
   assign tx_valid   = !tx_empty;
   assign tx_request = tx_empty;

   // ---------------- divisor latches ----------------
   logic [DIV_W-1:0] div_q;

   generate
      for (genvar b = 0; b < DIV_BYTES; b++) begin : g_div_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q[b*CHAR_W +: CHAR_W] <= '0;
            else if (bus_wr && divisor_access && bus_addr == REG_ADDR_W'(b))
               div_q[b*CHAR_W +: CHAR_W] <= bus_wdata[CHAR_W-1:0];
         end
      end
   endgenerate

   regpath_baudgen #(.DIV_W(DIV_W)) i_baudgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .divisor (div_q),
      .tick    (baud_tick)
   );

   // ---------------- read data ----------------
   logic [CHAR_W-1:0] rd_byte;
   always_comb begin
      rd_byte = '0;
      if (!divisor_access) begin
         if (bus_addr == REG_ADDR_W'(DATA_ADDR) && !rx_empty) rd_byte = rx_head;
      end else begin
         for (int b = 0; b < DIV_BYTES; b++)
            if (bus_addr == REG_ADDR_W'(b)) rd_byte = div_q[b*CHAR_W +: CHAR_W];
      end
   end
   assign bus_rdata = {{PAD_W{1'b0}}, rd_byte};

   // R2: a read in single register mode leaves the receive store empty
   assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && rx_read && !rx_char_valid) |=> !data_ready);

   // R6: a handoff in single register mode raises the transmit request
   assert_tx_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && tx_valid && tx_ready && !tx_write) |=> tx_request);

   // R12: a mode change leaves both stores empty
   assert_mode_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !rx_char_valid && !tx_write) |=> (!data_ready && tx_request));

endmodule

// File: tb/test_uart_regpath.sv
`timescale 1ns/1ps
module test_uart_regpath;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        divisor_access = 1'b0, fifo_en = 1'b0;
   logic [1:0]  word_len = 2'd3;
   logic        rx_char_valid = 1'b0;
   logic [7:0]  rx_char = '0;
   logic        tx_ready = 1'b0;
   logic        tx_valid, data_ready, tx_request, baud_tick;
   logic [7:0]  tx_data;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   uart_regpath i_uart_regpath (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .divisor_access(divisor_access),
      .fifo_en(fifo_en), .word_len(word_len), .rx_char_valid(rx_char_valid),
      .rx_char(rx_char), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .data_ready(data_ready), .tx_request(tx_request), .baud_tick(baud_tick)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] c);
      @(negedge clk);
      rx_char = c; rx_char_valid = 1'b1;
      @(negedge clk);
      rx_char_valid = 1'b0;
   endtask

   task automatic set_mode(input logic f);
      @(negedge clk);
      fifo_en = f;
      @(negedge clk);
   endtask

   task automatic set_divisor(input logic [15:0] v);
      divisor_access = 1'b1;
      bus_write(3'd0, {24'h0, v[7:0]});
      bus_write(3'd1, {24'h0, v[15:8]});
      divisor_access = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 data_ready", {31'b0, data_ready}, 32'd0);
      chk("R1 tx_request", {31'b0, tx_request}, 32'd1);
      chk("R1 tx_valid", {31'b0, tx_valid}, 32'd0);
      bus_read(3'd0, d); chk("R1 rx read", d, 32'd0);
      divisor_access = 1'b1;
      bus_read(3'd0, d); chk("R1 div low", d, 32'd0);
      bus_read(3'd1, d); chk("R1 div high", d, 32'd0);
      divisor_access = 1'b0;
   endtask

   task automatic t_rx_single();
      logic [31:0] d;
      push_rx(8'hA5);
      chk("R2 data_ready set", {31'b0, data_ready}, 32'd1);
      push_rx(8'h3C);
      bus_read(3'd0, d); chk("R2 overwrite read", d, 32'h3C);
      chk("R2 data_ready clear", {31'b0, data_ready}, 32'd0);
      bus_read(3'd0, d); chk("R2 empty after read", d, 32'd0);
   endtask

   task automatic t_wordlen();
      logic [31:0] d;
      word_len = 2'd0; push_rx(8'hFF);
      bus_read(3'd0, d); chk("R3 5 bit", d, 32'h1F);
      word_len = 2'd1; push_rx(8'hE6);
      bus_read(3'd0, d); chk("R3 6 bit", d, 32'h26);
      word_len = 2'd2; push_rx(8'hFF);
      bus_read(3'd0, d); chk("R3 7 bit", d, 32'h7F);
      word_len = 2'd3; push_rx(8'hC3);
      bus_read(3'd0, d); chk("R3 8 bit", d, 32'hC3);
   endtask

   task automatic t_rx_fifo();
      logic [31:0] d;
      set_mode(1'b1);
      for (int i = 0; i < 17; i++) push_rx(8'(i * 3 + 1));
      chk("R4 data_ready", {31'b0, data_ready}, 32'd1);
      for (int i = 0; i < 16; i++) begin
         bus_read(3'd0, d);
         chk("R4 order", d, 32'(i * 3 + 1));
         if (i == 14) chk("R4 ready while stored", {31'b0, data_ready}, 32'd1);
      end
      chk("R4 17th dropped", {31'b0, data_ready}, 32'd0);
   endtask

   task automatic t_empty_read();
      logic [31:0] d;
      bus_read(3'd0, d); chk("R5 empty read", d, 32'd0);
      push_rx(8'h77);
      bus_read(3'd0, d); chk("R5 next after empty read", d, 32'h77);
      chk("R5 ready clear", {31'b0, data_ready}, 32'd0);
   endtask

   task automatic t_tx_single();
      logic [31:0] d;
      set_mode(1'b0);
      bus_write(3'd0, 32'h5A);
      chk("R6 request drop", {31'b0, tx_request}, 32'd0);
      chk("R6 valid", {31'b0, tx_valid}, 32'd1);
      bus_write(3'd0, 32'h6B);
      chk("R6 overwrite", {24'b0, tx_data}, 32'h6B);
      bus_read(3'd0, d); chk("R8 read unaffected by write", d, 32'd0);
      @(negedge clk); tx_ready = 1'b1;
      @(negedge clk); tx_ready = 1'b0;
      chk("R6 request after handoff", {31'b0, tx_request}, 32'd1);
      chk("R6 valid after handoff", {31'b0, tx_valid}, 32'd0);
   endtask

   task automatic t_tx_fifo();
      set_mode(1'b1);
      for (int i = 0; i < 17; i++) bus_write(3'd0, 32'(8'h80 + i));
      chk("R7 request low", {31'b0, tx_request}, 32'd0);
      chk("R8 write not in rx", {31'b0, data_ready}, 32'd0);
      @(negedge clk); tx_ready = 1'b1;
      for (int i = 0; i < 16; i++) begin
         #1;
         chk("R7 head order", {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'(8'h80 + i)});
         @(negedge clk);
      end
      tx_ready = 1'b0;
      chk("R7 full write dropped", {31'b0, tx_valid}, 32'd0);
      chk("R7 request when empty", {31'b0, tx_request}, 32'd1);
   endtask

   task automatic t_mode_flush();
      push_rx(8'h11); push_rx(8'h22);
      bus_write(3'd0, 32'h33);
      set_mode(1'b0);
      chk("R12 rx flushed", {31'b0, data_ready}, 32'd0);
      chk("R12 tx flushed", {31'b0, tx_request}, 32'd1);
   endtask

   task automatic t_divisor();
      logic [31:0] d;
      push_rx(8'h4D);
      set_divisor(16'h1234);
      chk("R9 tx untouched", {31'b0, tx_request}, 32'd1);
      divisor_access = 1'b1;
      bus_read(3'd0, d); chk("R9 low latch", d, 32'h34);
      bus_read(3'd1, d); chk("R9 high latch", d, 32'h12);
      chk("R9 rx untouched", {31'b0, data_ready}, 32'd1);
      bus_write(3'd0, 32'hDEADBE05);
      bus_read(3'd0, d); chk("R11 reserved bits zero", d, 32'h05);
      divisor_access = 1'b0;
      bus_read(3'd0, d); chk("R9 rx char kept", d, 32'h4D);
   endtask

   task automatic measure_gap(input string req, input int exp);
      int gap;
      int guard;
      guard = 0;
      @(negedge clk);
      while (!baud_tick && guard < 1000) begin @(negedge clk); guard++; end
      gap = 0;
      do begin @(negedge clk); gap++; end while (!baud_tick && gap < 1000);
      chk(req, 32'(gap), 32'(exp));
   endtask

   task automatic t_baud();
      set_divisor(16'd5);
      measure_gap("R10 divisor 5", 5);
      set_divisor(16'h0100);
      measure_gap("R10 divisor 256", 256);
      set_divisor(16'd0);
      begin
         int hits;
         hits = 0;
         for (int i = 0; i < 8; i++) begin @(negedge clk); if (baud_tick) hits++; end
         chk("R10 zero divisor acts as 1", 32'(hits), 32'd8);
      end
      measure_gap("R10 divisor 1 gap", 1);
   endtask

   initial begin
      #1_000_000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rx_single();
      t_wordlen();
      t_rx_fifo();
      t_empty_read();
      t_tx_single();
      t_tx_fifo();
      t_mode_flush();
      t_divisor();
      t_baud();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule